// File: doc/BRIEF.md
# Predicated Vector Carry-Add Sequencer

This block adds two stored vectors of 16-bit elements, one element per clock, under a single predicate mask. Each element has its own carry bit. That bit supplies the carry-in for the element's addition and receives the carry-out afterwards. There is no shared carry or overflow flag, so no element's result depends on another element's carry. Large additions can therefore run as wide batches of independent lanes. Software-side logic can then inspect the carry bits and propagate them in a later pass.

The element arrays sit inside the block. Before an operation, a load port fills them: source A, source B, the destination, and the carry bit. Once the operation completes, a readback port returns the destination value and the carry bit. A start pulse captures three things: a vector length, a 64-bit predicate mask, and a flag that says whether the mask applies. The sequencer then walks the element index upward from zero. The current index is presented as a saved-state output, so an interrupted operation could be resumed from it.

Top module: `vec_carry_add_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `state_idx` is 0.
- R2: For every processed element i, the destination becomes (A[i] + B[i] + carry[i]) modulo 2^16.
- R3: For every processed element i, carry[i] becomes the carry-out of that 17-bit sum. The next run then uses it as that element's carry-in, and it never affects any other element.
- R4: Element i is processed only when bit i of the captured mask is 1. Elements with a 0 bit keep their destination and carry bit unchanged.
- R5: When `start_has_mask` is 0, `start_mask` is ignored and every element below VL is processed.
- R6: A start pulse with VL from 1 to 64 raises `busy` on the next edge. The block processes indices 0 to VL-1 in consecutive cycles and touches no element at or above VL. `done` pulses for one cycle in the cycle after the last element. `state_idx` then reads VL.
- R7: A start pulse with VL = 0 produces `done` on the next edge, never raises `busy`, and writes no element.
- R8: While `busy` is 1, `start` and `ld_en` are ignored.
- R9: `rd_sum` and `rd_carry` show the element at `rd_addr` one clock edge after the address is applied.
- R10: The source step and the destination step always hold the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one element slot (ignored while busy) |
| ld_addr | input | 6 | Element slot to load |
| ld_a | input | 16 | Source A value |
| ld_b | input | 16 | Source B value |
| ld_d | input | 16 | Initial destination value |
| ld_carry | input | 1 | Initial per-element carry bit |
| rd_addr | input | 6 | Element slot to read back |
| rd_sum | output | 16 | Destination value, one cycle after address |
| rd_carry | output | 1 | Carry bit, one cycle after address |
| start | input | 1 | Begin an operation (ignored while busy) |
| start_vl | input | 7 | Vector length 0 to 64 |
| start_mask | input | 64 | Predicate, bit i gates element i |
| start_has_mask | input | 1 | 1: use start_mask, 0: all ones |
| busy | output | 1 | Element loop running |
| done | output | 1 | One-cycle completion pulse |
| state_idx | output | 7 | Saved element index |

## Verification
The hardest case to reach from the ports is a start pulse or a load that arrives in the middle of a run. It must change neither the run length nor the element the run will write later. The stimulus issues a second start and a load aimed at a not-yet-processed slot one cycle into a four-element run. It then confirms the cycle count and that slot's final value. Carry independence is reached by running the same vectors twice, so the second pass consumes the carry bits written by the first. Full-length and boundary behaviour uses a 64-element run with only the end predicate bits set.

// File: rtl/vca_pkg.sv
package vca_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/vca_carry_adder.sv
module vca_carry_adder #(
  parameter int ELEM_W = 16
) (
  input  logic [ELEM_W-1:0] op_a,
  input  logic [ELEM_W-1:0] op_b,
  input  logic              cin,
  output logic [ELEM_W-1:0] sum,
  output logic              cout
);
  localparam int SUM_W = ELEM_W + 1;

  logic [SUM_W-1:0] full;

  always_comb begin
    full = {1'b0, op_a} + {1'b0, op_b} + {{ELEM_W{1'b0}}, cin};
    sum  = full[ELEM_W-1:0];
    cout = full[SUM_W-1];
  end
endmodule

// File: rtl/vca_elem_store.sv
module vca_elem_store #(
  parameter int ELEM_W = 16,
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [ELEM_W-1:0] ld_a,
  input  logic [ELEM_W-1:0] ld_b,
  input  logic [ELEM_W-1:0] ld_d,
  input  logic              ex_we,
  input  logic [AW-1:0]     ex_addr,
  input  logic [ELEM_W-1:0] ex_d,
  output logic [ELEM_W-1:0] ex_a,
  output logic [ELEM_W-1:0] ex_b,
  input  logic [AW-1:0]     rd_addr,
  output logic [ELEM_W-1:0] rd_d
);
  logic [ELEM_W-1:0] a_mem [DEPTH];
  logic [ELEM_W-1:0] b_mem [DEPTH];
  logic [ELEM_W-1:0] d_mem [DEPTH];

  logic              d_we;
  logic [AW-1:0]     d_waddr;
  logic [ELEM_W-1:0] d_wdata;

  // Load and execute never overlap, so one write port serves both.
  always_comb begin
    d_we    = ld_we | ex_we;
    d_waddr = ex_we ? ex_addr : ld_addr;
    d_wdata = ex_we ? ex_d    : ld_d;
  end

  always_ff @(posedge clk) begin
    if (ld_we) a_mem[ld_addr] <= ld_a;
  end

  always_ff @(posedge clk) begin
    if (ld_we) b_mem[ld_addr] <= ld_b;
  end

  always_ff @(posedge clk) begin
    if (d_we) d_mem[d_waddr] <= d_wdata;
  end

  always_ff @(posedge clk) begin
    rd_d <= d_mem[rd_addr];
  end

  assign ex_a = a_mem[ex_addr];
  assign ex_b = b_mem[ex_addr];
endmodule

// File: rtl/vca_carry_bits.sv
module vca_carry_bits #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_bit,
  input  logic          ex_we,
  input  logic [AW-1:0] ex_addr,
  input  logic          ex_bit,
  output logic          ex_cin,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [DEPTH-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      rd_bit  <= 1'b0;
    end else begin
      if (ex_we)      flags_q[ex_addr] <= ex_bit;
      else if (ld_we) flags_q[ld_addr] <= ld_bit;
      rd_bit <= flags_q[rd_addr];
    end
  end

  assign ex_cin = flags_q[ex_addr];
endmodule

// File: rtl/vca_step_ctrl.sv
module vca_step_ctrl
  import vca_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LW-1:0]    start_vl,
  input  logic [DEPTH-1:0] start_mask,
  input  logic             start_has_mask,
  output logic             busy,
  output logic             done,
  output logic [LW-1:0]    src_idx,
  output logic [LW-1:0]    dst_idx,
  output logic             elem_we,
  output logic [AW-1:0]    elem_addr
);
  localparam logic [LW-1:0] VL_MAX = LW'(DEPTH);
  localparam logic [LW-1:0] ONE    = LW'(1);

  seq_state_t       state_q;
  logic [LW-1:0]    vl_q;
  logic [DEPTH-1:0] mask_q;
  logic [LW-1:0]    vl_in;

  always_comb begin
    vl_in = (start_vl > VL_MAX) ? VL_MAX : start_vl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      mask_q  <= '0;
      src_idx <= '0;
      dst_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            vl_q    <= vl_in;
            mask_q  <= start_has_mask ? start_mask : '1;
            src_idx <= '0;
            dst_idx <= '0;
            if (vl_in == '0) done    <= 1'b1;
            else             state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          src_idx <= src_idx + ONE;
          dst_idx <= dst_idx + ONE;
          if (dst_idx == vl_q - ONE) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q == ST_RUN);
    elem_addr = src_idx[AW-1:0];
    elem_we   = busy && mask_q[elem_addr];
  end
endmodule

// File: rtl/vec_carry_add_seq.sv
module vec_carry_add_seq #(
  parameter int ELEM_W = 16,
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH),
  parameter int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [ELEM_W-1:0] ld_a,
  input  logic [ELEM_W-1:0] ld_b,
  input  logic [ELEM_W-1:0] ld_d,
  input  logic              ld_carry,
  input  logic [AW-1:0]     rd_addr,
  output logic [ELEM_W-1:0] rd_sum,
  output logic              rd_carry,
  input  logic              start,
  input  logic [LW-1:0]     start_vl,
  input  logic [DEPTH-1:0]  start_mask,
  input  logic              start_has_mask,
  output logic              busy,
  output logic              done,
  output logic [LW-1:0]     state_idx
);
  logic              ld_ok;
  logic [LW-1:0]     src_idx;
  logic [LW-1:0]     dst_idx;
  logic              elem_we;
  logic [AW-1:0]     elem_addr;
  logic [ELEM_W-1:0] op_a;
  logic [ELEM_W-1:0] op_b;
  logic              cin;
  logic [ELEM_W-1:0] sum;
  logic              cout;
  logic              start_ok;

  assign ld_ok     = ld_en & ~busy;
  assign start_ok  = start & ~busy;
  assign state_idx = dst_idx;

  vca_step_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start          (start_ok),
    .start_vl       (start_vl),
    .start_mask     (start_mask),
    .start_has_mask (start_has_mask),
    .busy           (busy),
    .done           (done),
    .src_idx        (src_idx),
    .dst_idx        (dst_idx),
    .elem_we        (elem_we),
    .elem_addr      (elem_addr)
  );

  vca_elem_store #(.ELEM_W(ELEM_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .ld_we   (ld_ok),
    .ld_addr (ld_addr),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .ld_d    (ld_d),
    .ex_we   (elem_we),
    .ex_addr (elem_addr),
    .ex_d    (sum),
    .ex_a    (op_a),
    .ex_b    (op_b),
    .rd_addr (rd_addr),
    .rd_d    (rd_sum)
  );

  vca_carry_bits #(.DEPTH(DEPTH), .AW(AW)) u_carry (
    .clk     (clk),
    .rst     (rst),
    .ld_we   (ld_ok),
    .ld_addr (ld_addr),
    .ld_bit  (ld_carry),
    .ex_we   (elem_we),
    .ex_addr (elem_addr),
    .ex_bit  (cout),
    .ex_cin  (cin),
    .rd_addr (rd_addr),
    .rd_bit  (rd_carry)
  );

  vca_carry_adder #(.ELEM_W(ELEM_W)) u_add (
    .op_a (op_a),
    .op_b (op_b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );
endmodule

// File: rtl/vca_seq_checker.sv
module vca_seq_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [LW-1:0] start_vl,
  input logic          busy,
  input logic          done,
  input logic [LW-1:0] state_idx,
  input logic [LW-1:0] src_idx,
  input logic [LW-1:0] dst_idx,
  input logic          elem_we
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_IDX_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    busy |=> (state_idx == $past(state_idx) + LW'(1))); // R6

  AST_RUN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (state_idx == '0)); // R6

  AST_ZERO_VL_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && start_vl == '0) |=> (done && !busy)); // R7

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    elem_we |-> busy); // R4

  AST_STEPS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    src_idx == dst_idx); // R10
endmodule

bind vec_carry_add_seq vca_seq_checker #(.LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_vl  (start_vl),
  .busy      (busy),
  .done      (done),
  .state_idx (state_idx),
  .src_idx   (src_idx),
  .dst_idx   (dst_idx),
  .elem_we   (elem_we)
);

// File: tb/vec_carry_add_seq_tb.sv
module vec_carry_add_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [5:0]  ld_addr;
  logic [15:0] ld_a, ld_b, ld_d;
  logic        ld_carry;
  logic [5:0]  rd_addr;
  logic [15:0] rd_sum;
  logic        rd_carry;
  logic        start;
  logic [6:0]  start_vl;
  logic [63:0] start_mask;
  logic        start_has_mask;
  logic        busy, done;
  logic [6:0]  state_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  vec_carry_add_seq u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_a(ld_a),
    .ld_b(ld_b), .ld_d(ld_d), .ld_carry(ld_carry), .rd_addr(rd_addr),
    .rd_sum(rd_sum), .rd_carry(rd_carry), .start(start), .start_vl(start_vl),
    .start_mask(start_mask), .start_has_mask(start_has_mask), .busy(busy),
    .done(done), .state_idx(state_idx)
  );

  // {a, b, carry-in}
  localparam logic [32:0] VEC [8] = '{
    {16'h0001, 16'h0002, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1},
    {16'h8000, 16'h8000, 1'b0},
    {16'h1234, 16'h4321, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1},
    {16'h0000, 16'h0000, 1'b0},
    {16'h7FFF, 16'h0000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int addr, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] d, input logic c);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 6'(addr); ld_a = a; ld_b = b; ld_d = d; ld_carry = c;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [15:0] s, output logic c);
    @(negedge clk);
    rd_addr = 6'(addr);
    @(negedge clk);
    s = rd_sum;
    c = rd_carry;
  endtask

  task automatic run_vec(input int vl, input logic [63:0] m, input logic hm,
                         output int cyc);
    @(negedge clk);
    start = 1'b1; start_vl = 7'(vl); start_mask = m; start_has_mask = hm;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [16:0] add17(input logic [15:0] a, input logic [15:0] b,
                                        input logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic        c;
    logic [16:0] e;
    logic [15:0] s_prev;
    logic        c_prev;
    int          cyc;

    rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_a = '0; ld_b = '0; ld_d = '0;
    ld_carry = 1'b0; rd_addr = '0; start = 1'b0; start_vl = '0; start_mask = '0;
    start_has_mask = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(done == 1'b0, "R1 done", 32'(done), 0);
    chk(state_idx == 7'd0, "R1 state_idx", 32'(state_idx), 0);

    // Table walk, no mask (R2, R3, R5, R6)
    for (int i = 0; i < 8; i++)
      load(i, VEC[i][32:17], VEC[i][16:1], 16'hDEAD, VEC[i][0]);
    load(8, 16'h0001, 16'h0001, 16'h5A5A, 1'b1);
    run_vec(8, 64'h0, 1'b0, cyc);
    chk(cyc == 9, "R6 run length", 32'(cyc), 9);
    chk(state_idx == 7'd8, "R6 state_idx end", 32'(state_idx), 8);
    for (int i = 0; i < 8; i++) begin
      rd(i, s, c);
      e = add17(VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
      chk(s == e[15:0], "R2/R5 sum", 32'(s), 32'(e[15:0]));
      chk(c == e[16], "R3 carry", 32'(c), 32'(e[16]));
    end
    rd(8, s, c);
    chk(s == 16'h5A5A && c == 1'b1, "R6 beyond VL untouched", {15'd0, c, s}, 32'h15A5A);

    // Second pass consumes the carry bits from the first (R3)
    run_vec(8, 64'h0, 1'b0, cyc);
    for (int i = 0; i < 8; i++) begin
      logic [16:0] e1;
      e1 = add17(VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
      e  = add17(VEC[i][32:17], VEC[i][16:1], e1[16]);
      rd(i, s, c);
      chk({c, s} == e, "R3 carry reuse", 32'({c, s}), 32'(e));
    end

    // Masked run 0xA5 (R4)
    for (int i = 0; i < 8; i++)
      load(i, VEC[i][32:17], VEC[i][16:1], 16'hBEEF, VEC[i][0]);
    run_vec(8, 64'hA5, 1'b1, cyc);
    chk(cyc == 9, "R4 run length", 32'(cyc), 9);
    for (int i = 0; i < 8; i++) begin
      rd(i, s, c);
      if ((8'hA5 >> i) & 1) e = add17(VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
      else                  e = {VEC[i][0], 16'hBEEF};
      chk({c, s} == e, "R4 masked", 32'({c, s}), 32'(e));
    end

    // Full length, only end bits active (R4, R6)
    for (int i = 0; i < 64; i++)
      load(i, 16'(i * 1000), 16'(i * 3), 16'h0F0F, i[0]);
    run_vec(64, {1'b1, 62'd0, 1'b1}, 1'b1, cyc);
    chk(cyc == 65, "R6 full run length", 32'(cyc), 65);
    chk(state_idx == 7'd64, "R6 state_idx 64", 32'(state_idx), 64);
    rd(63, s, c);
    e = add17(16'(63 * 1000), 16'(63 * 3), 1'b1);
    chk({c, s} == e, "R2 element 63", 32'({c, s}), 32'(e));
    rd(0, s, c);
    chk({c, s} == 17'h00000, "R2 element 0", 32'({c, s}), 0);
    rd(32, s, c);
    chk({c, s} == 17'h00F0F, "R4 element 32 kept", 32'({c, s}), 32'h0F0F);

    // VL = 0 (R7)
    rd(63, s_prev, c_prev);
    @(negedge clk);
    start = 1'b1; start_vl = 7'd0; start_has_mask = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R7 immediate done", {30'd0, done, busy}, 2);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 32'(done), 0);
    rd(0, s, c);
    chk({c, s} == 17'h00000, "R7 element 0 unchanged", 32'({c, s}), 0);
    rd(63, s, c);
    chk({c, s} == {c_prev, s_prev}, "R7 element 63 unchanged", 32'({c, s}),
        32'({c_prev, s_prev}));

    // Start and load while busy (R8)
    for (int i = 0; i < 4; i++)
      load(i, 16'(100 * (i + 1)), 16'(7 + i), 16'h0000, 1'b0);
    @(negedge clk);
    start = 1'b1; start_vl = 7'd4; start_has_mask = 1'b0;
    @(negedge clk);
    start = 1'b1; start_vl = 7'd2; start_has_mask = 1'b1; start_mask = 64'h0;
    ld_en = 1'b1; ld_addr = 6'd3; ld_a = 16'hFFFF; ld_b = 16'hFFFF;
    ld_d = 16'h7777; ld_carry = 1'b1;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    cyc = 2;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 5, "R8 run length", 32'(cyc), 5);
    chk(state_idx == 7'd4, "R8 state_idx", 32'(state_idx), 4);
    rd(3, s, c);
    chk({c, s} == 17'(400 + 10), "R8 load ignored", 32'({c, s}), 410);

    // Readback latency (R9)
    rd(0, s, c);
    @(negedge clk);
    rd_addr = 6'd1;
    #1;
    chk(rd_sum == s, "R9 before edge", 32'(rd_sum), 32'(s));
    @(negedge clk);
    chk(rd_sum == 16'(200 + 8), "R9 after edge", 32'(rd_sum), 208);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule